// File: doc/BRIEF.md
# Input Combiner and Glitch Filter

This block conditions two single-bit digital pin inputs, A and B, before a pin's main function sees them. A 3-bit mode input selects one of two kinds of treatment. The first kind is a logic merge: the A path carries A, A AND B, A OR B or A XOR B, and B is passed through unchanged. The second kind is deglitching. Each input goes through its own three-sample filter that changes its output only when all three samples agree.

A filter takes a new sample only on a one-cycle strobe. That strobe comes from one of four shared sample-rate timebases generated elsewhere in the chip, and the low two mode bits choose which one. Both outputs are registered, so every input and every mode change appears on the outputs one clock edge later.

The inputs and outputs are continuous pin levels, not data transfers. For that reason the block has no valid/ready handshake and applies no back-pressure: the outputs are simply re-evaluated at every clock edge.

Top module: `pinc_cond_top`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become 0 after that edge and all sample history is cleared.
- R2: Mode 000 (the default) makes `out_a` equal `in_a` and `out_b` equal `in_b` as sampled at the previous clock edge.
- R3: Mode 001 makes `out_a` equal the AND of `in_a` and `in_b` sampled at the previous edge.
- R4: Mode 010 makes `out_a` equal the OR of `in_a` and `in_b` sampled at the previous edge.
- R5: Mode 011 makes `out_a` equal the XOR of `in_a` and `in_b` sampled at the previous edge.
- R6: In modes 001, 010 and 011, `out_b` equals `in_b` sampled at the previous edge.
- R7: Modes 1xx filter both inputs, and mode bits [1:0] pick strobe `rate_stb[mode[1:0]]`. For example, 100 selects bit 0 and 111 selects bit 3.
- R8: In a filtered mode, a filter takes a sample only at an edge where the selected strobe is 1. Input changes, and the strobes that are not selected, have no effect on the outputs.
- R9: A filtered output switches to level L only at a sampling edge after which its last three samples are all L. In every other case it holds its value, so a glitch shorter than three samples is removed.
- R10: At the edge where the mode goes from 0xx to 1xx, the history of each filter is loaded with three copies of the current input, and the filter output takes that input level. A change between two filtered modes keeps the history as it is.
- R11: A new mode value governs the outputs from the first clock edge at which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | Raw A input |
| in_b | input | 1 | Raw B input |
| mode | input | 3 | Conditioning mode |
| rate_stb | input | 4 | One-cycle sample strobes of the four shared timebases |
| out_a | output | 1 | Conditioned A |
| out_b | output | 1 | Conditioned B |

## Verification
The assertions assume that `rst` is held for at least one edge before normal operation. They also assume that `mode` and the strobes are synchronous levels that are valid at every edge; nothing in the design depends on a strobe being a single-cycle pulse.

The stimulus changes inputs only between edges and raises one strobe bit at a time. It also includes deliberate pulses on strobes that are not selected, to show they are ignored.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam int MODE_W    = 3;
  localparam int SEL_W     = MODE_W - 1;
  localparam int NUM_RATES = 2 ** SEL_W;
  localparam int NUM_CH    = 2;

  typedef enum logic [MODE_W-1:0] {
    M_PASS = 3'b000,
    M_AND  = 3'b001,
    M_OR   = 3'b010,
    M_XOR  = 3'b011
  } comb_mode_e;
endpackage

// File: rtl/pinc_combiner.sv
module pinc_combiner
  import pinc_pkg::*;
(
  input  logic [SEL_W-1:0] op,
  input  logic             a,
  input  logic             b,
  output logic             ya,
  output logic             yb
);
  always_comb begin
    yb = b;
    unique case (comb_mode_e'({1'b0, op}))
      M_AND:   ya = a & b;
      M_OR:    ya = a | b;
      M_XOR:   ya = a ^ b;
      default: ya = a;
    endcase
  end
endmodule

// File: rtl/pinc_rate_sel.sv
module pinc_rate_sel
  import pinc_pkg::*;
(
  input  logic [NUM_RATES-1:0] stb,
  input  logic [SEL_W-1:0]     sel,
  output logic                 pick
);
  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_RATES; i++)
      if (sel == SEL_W'(i)) pick = stb[i];
  end
endmodule

// File: rtl/pinc_deglitch.sv
module pinc_deglitch #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sample_en,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] hist;
  logic [DEPTH-1:0] hist_nxt;

  assign hist_nxt = {hist[DEPTH-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      dout <= 1'b0;
    end else if (load) begin
      hist <= {DEPTH{din}};
      dout <= din;
    end else if (sample_en) begin
      hist <= hist_nxt;
      if (&hist_nxt)       dout <= 1'b1;
      else if (~|hist_nxt) dout <= 1'b0;
    end
  end

  // R8/R9: without a sample or a load the output holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && !$past(sample_en)) |-> $stable(dout));
  // R9: rising only with a unanimous history of ones
  p_unan_rise_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(dout) && !$past(load)) |-> (&hist));
  // R9: falling only with a unanimous history of zeros
  p_unan_fall_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(dout) && !$past(load)) |-> (~|hist));
  // R10: a load copies the input level to the output
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> (dout == $past(din)));
endmodule

// File: rtl/pinc_cond_top.sv
module pinc_cond_top
  import pinc_pkg::*;
#(
  parameter int FILT_DEPTH = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_a,
  input  logic                 in_b,
  input  logic [MODE_W-1:0]    mode,
  input  logic [NUM_RATES-1:0] rate_stb,
  output logic                 out_a,
  output logic                 out_b
);
  logic              filt_mode;
  logic              filt_mode_q;
  logic              load;
  logic              rate_pick;
  logic              sample_en;
  logic              comb_a, comb_b;
  logic [NUM_CH-1:0] comb_q;
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] filt_q;

  assign filt_mode = mode[MODE_W-1];
  assign raw       = {in_b, in_a};
  assign load      = filt_mode & ~filt_mode_q;
  assign sample_en = filt_mode & rate_pick & ~load;

  pinc_combiner u_comb (
    .op (mode[SEL_W-1:0]),
    .a  (in_a),
    .b  (in_b),
    .ya (comb_a),
    .yb (comb_b)
  );

  pinc_rate_sel u_rsel (
    .stb  (rate_stb),
    .sel  (mode[SEL_W-1:0]),
    .pick (rate_pick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pinc_deglitch #(.DEPTH(FILT_DEPTH)) u_dg (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .sample_en (sample_en),
      .din       (raw[c]),
      .dout      (filt_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_mode_q <= 1'b0;
      comb_q      <= '0;
    end else begin
      filt_mode_q <= filt_mode;
      comb_q      <= {comb_b, comb_a};
    end
  end

  assign out_a = filt_mode_q ? filt_q[0] : comb_q[0];
  assign out_b = filt_mode_q ? filt_q[1] : comb_q[1];

  // R2: pass-through of A in the default mode
  p_pass_a_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == M_PASS) |-> (out_a == $past(in_a)));
  // R3: AND merge on the A path
  p_and_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == M_AND) |-> (out_a == ($past(in_a) & $past(in_b))));
  // R5: XOR merge on the A path
  p_xor_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == M_XOR) |-> (out_a == ($past(in_a) ^ $past(in_b))));
  // R6: B passes through in every unfiltered mode
  p_bpass_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode[MODE_W-1])) |-> (out_b == $past(in_b)));
  // R1: outputs are low right after a reset edge
  p_rst_low_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_a && !out_b));
endmodule

// File: tb/test_pinc_cond_top.sv
module test_pinc_cond_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_a, in_b;
  logic [2:0] mode;
  logic [3:0] rate_stb;
  logic       out_a, out_b;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #4 clk = ~clk;

  pinc_cond_top i_pinc_cond_top (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .mode(mode), .rate_stb(rate_stb), .out_a(out_a), .out_b(out_b)
  );

  // {mode[2:0], a, b, expected_a, expected_b}
  localparam logic [6:0] VEC [16] = '{
    7'b000_00_00, 7'b000_01_01, 7'b000_10_10, 7'b000_11_11,
    7'b001_00_00, 7'b001_01_01, 7'b001_10_00, 7'b001_11_11,
    7'b010_00_00, 7'b010_01_11, 7'b010_10_10, 7'b010_11_11,
    7'b011_00_00, 7'b011_01_11, 7'b011_10_10, 7'b011_11_01
  };

  task automatic chk(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic a, input logic b,
                      input logic [3:0] s);
    mode = m; in_a = a; in_b = b; rate_stb = s;
    @(posedge clk); #1;
    rate_stb = 4'b0000;
  endtask

  initial begin
    rst = 1'b1; mode = 3'b000; in_a = 1'b1; in_b = 1'b1; rate_stb = 4'b1111;
    @(posedge clk); #1;
    chk("R1 reset out_a", out_a, 1'b0);
    chk("R1 reset out_b", out_b, 1'b0);
    @(posedge clk); #1;
    rst = 1'b0; rate_stb = 4'b0000;

    // table: R2 R3 R4 R5 R6
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][6:4], VEC[i][3], VEC[i][2], 4'b0000);
      chk($sformatf("R2-R6 row %0d a", i), out_a, VEC[i][1]);
      chk($sformatf("R6 row %0d b", i), out_b, VEC[i][0]);
    end

    // R11: mode switch effective at next edge
    step(3'b000, 1'b1, 1'b0, 4'b0000);
    chk("R11 pass", out_a, 1'b1);
    step(3'b001, 1'b1, 1'b0, 4'b0000);
    chk("R11 and after switch", out_a, 1'b0);

    // R10: entering filtered mode loads current level
    step(3'b100, 1'b1, 1'b0, 4'b0000);
    chk("R10 load a", out_a, 1'b1);
    chk("R10 load b", out_b, 1'b0);

    // R8: no strobe, input changes ignored
    step(3'b100, 1'b0, 1'b1, 4'b0000);
    step(3'b100, 1'b0, 1'b1, 4'b0000);
    chk("R8 no strobe a", out_a, 1'b1);
    chk("R8 no strobe b", out_b, 1'b0);

    // R9: need three agreeing samples on rate 0
    step(3'b100, 1'b0, 1'b1, 4'b0001);
    chk("R9 one sample a", out_a, 1'b1);
    step(3'b100, 1'b0, 1'b1, 4'b0010); // R8 unselected strobe ignored
    step(3'b100, 1'b0, 1'b1, 4'b1000);
    step(3'b100, 1'b0, 1'b1, 4'b0001);
    chk("R8 R9 two samples a", out_a, 1'b1);
    chk("R8 R9 two samples b", out_b, 1'b0);
    step(3'b100, 1'b0, 1'b1, 4'b0001);
    chk("R9 three samples a", out_a, 1'b0);
    chk("R9 three samples b", out_b, 1'b1);

    // R9: short glitch removed
    step(3'b100, 1'b1, 1'b0, 4'b0001);
    step(3'b100, 1'b0, 1'b1, 4'b0001);
    chk("R9 glitch a", out_a, 1'b0);
    chk("R9 glitch b", out_b, 1'b1);

    // R7 R10: move to rate 3, history kept (no load)
    step(3'b111, 1'b1, 1'b0, 4'b0000);
    chk("R10 no reload a", out_a, 1'b0);
    step(3'b111, 1'b1, 1'b0, 4'b0001); // rate 0 now unselected
    step(3'b111, 1'b1, 1'b0, 4'b1000);
    step(3'b111, 1'b1, 1'b0, 4'b1000);
    chk("R7 two rate3 samples a", out_a, 1'b0);
    step(3'b111, 1'b1, 1'b0, 4'b1000);
    chk("R7 three rate3 samples a", out_a, 1'b1);
    chk("R7 three rate3 samples b", out_b, 1'b0);

    // R1: reset mid-run
    rst = 1'b1;
    step(3'b111, 1'b1, 1'b1, 4'b1000);
    chk("R1 mid reset a", out_a, 1'b0);
    chk("R1 mid reset b", out_b, 1'b0);
    rst = 1'b0;
    step(3'b000, 1'b0, 1'b1, 4'b0000);
    chk("R2 after reset b", out_b, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule